// File: doc/BRIEF.md
# Write Delay Normalizer and Register Encoder

This block takes a three-level write delay (a frame count, a coarse step and an eight-position phase) together with a speed-mode flag. It folds the value into its legal digit ranges, saturates it when the frame digit leaves its range, and merges the result into a 32-bit control register word. The delay arrives as three small signed numbers, each possibly one step past either end of its range. This lets a search loop add or subtract one unit from any digit and hand the raw result straight to the block.

The phase digit always has radix 8. The step digit has radix 11 in normal mode and radix 12 in fast mode. Carries and borrows ripple phase → step → frame, with at most one per digit. Two items are derived from the folded step value: a two-bit region code, compared against thresholds that depend on the mode, and, in fast mode only, a rule that pins the programmed phase to 4 near the step 9/10 boundary. All bits of the word outside the delay fields are copied from a supplied current register value.

A two-state controller sequences the block. `ST_IDLE` is the rest state. A strobe on `in_valid` in either state moves to `ST_EMIT`, which presents one valid result. From `ST_EMIT`, no strobe returns to `ST_IDLE` and a new strobe stays in `ST_EMIT`.

Top module: `wdly_encoder`

## Requirements
- R1: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high, and the outputs then reflect the inputs of that strobe cycle. Without a strobe, `out_valid` is low and all result outputs hold their last value.
- R2: The phase digit has radix 8. An input phase of 8..15 subtracts 8 and adds one step. An input phase of -8..-1 adds 8 and removes one step.
- R3: The step digit has radix 11 when `fast_mode`=0 and radix 12 when `fast_mode`=1. A step at or above the radix subtracts the radix and adds one frame. A negative step adds the radix and removes one frame. Supported inputs are step in [-(radix-1), 2·radix-2] and phase in [-8, 15].
- R4: If the carried frame is negative, `out_f`, `out_t` and `out_p` are all 0 and `out_err` is 1.
- R5: If the carried frame is 4 or more, the outputs become `out_f`=3, `out_t`=radix-1 and `out_p`=7, and `out_err` is 1.
- R6: When the carried frame lies in 0..3, `out_err` is 0 and the outputs are the normalized digits.
- R7: When `fast_mode`=1, the phase written into the word is 4 if the step is 9 and the phase is at least 4, or if the step is 10 and the phase is below 4. Otherwise, and always when `fast_mode`=0, the phase written is `out_p`.
- R8: The region code is 2'b11 when the step is at or below the low threshold, and 2'b01 when it is above the high threshold. Otherwise it is 2'b00. The thresholds are low=1 and high=6 when `fast_mode`=0, and low=2 and high=9 when `fast_mode`=1.
- R9: The word carries the step in [31:28], the programmed phase in [26:24], the frame in [19:18] and the region code in [17:16].
- R10: Word bits 27, 23:20 and 15:0 equal the corresponding bits of `cur_word` sampled at the strobe.
- R11: After reset, `out_valid`, `out_err`, `out_word` and the digit outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: sample the inputs this cycle |
| fast_mode | input | 1 | 1 selects step radix 12 and the fast-mode thresholds and phase rule |
| in_f | input | 6 | Signed frame digit |
| in_t | input | 6 | Signed step digit |
| in_p | input | 6 | Signed phase digit |
| cur_word | input | 32 | Current register value; supplies the bits outside the delay fields |
| out_valid | output | 1 | Result valid, one cycle after a strobe |
| out_word | output | 32 | Packed register word |
| out_f | output | 2 | Normalized frame |
| out_t | output | 4 | Normalized step |
| out_p | output | 3 | Normalized phase, before the fast-mode rule |
| out_err | output | 1 | Saturation occurred |

## Verification
The assertions check on every valid cycle that the strobe-to-valid timing holds, that the step stays below the radix of the sampled mode, and that saturated results take one of the two permitted shapes. They also check that the word's delay fields agree with the digit outputs, that passthrough bits match the sampled current word, and that the phase rule never acts in normal mode. The exact carry arithmetic, the threshold edges of the region code and the boundary cases of the phase rule can only be shown by the bench. It compares directed corner values and seeded random deltas against its own model.

// File: rtl/wdly_pkg.sv
package wdly_pkg;
    localparam int F_W = 2;
    localparam int T_W = 4;
    localparam int P_W = 3;
    localparam int WORD_W = 32;
    // field positions in the control word (decoded by the delay line)
    localparam int T_LSB = 28;
    localparam int P_LSB = 24;
    localparam int F_LSB = 18;
    localparam int R_LSB = 16;

    typedef struct packed {
        logic [F_W-1:0] f;
        logic [T_W-1:0] t;
        logic [P_W-1:0] p;
        logic           err;
    } wdly_norm_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } wdly_state_e;
endpackage

// File: rtl/wdly_normalize.sv
module wdly_normalize
    import wdly_pkg::*;
#(
    parameter int IN_W       = 6,
    parameter int RADIX_SLOW = 11,
    parameter int RADIX_FAST = 12,
    parameter int F_LEVELS   = 4
) (
    input  logic                   fast,
    input  logic signed [IN_W-1:0] raw_f,
    input  logic signed [IN_W-1:0] raw_t,
    input  logic signed [IN_W-1:0] raw_p,
    output wdly_norm_t             norm
);
    localparam int NW = IN_W + 2;
    localparam logic signed [NW-1:0] ONE   = NW'(1);
    localparam logic signed [NW-1:0] ZERO  = NW'(0);
    localparam logic signed [NW-1:0] P_RAD = NW'(1 << P_W);
    localparam logic signed [NW-1:0] R_S   = NW'(RADIX_SLOW);
    localparam logic signed [NW-1:0] R_F   = NW'(RADIX_FAST);
    localparam logic signed [NW-1:0] F_TOP = NW'(F_LEVELS);

    logic signed [NW-1:0] radix, p1, t0, t1, f0;

    always_comb begin
        radix = fast ? R_F : R_S;
        p1 = {{2{raw_p[IN_W-1]}}, raw_p};
        t0 = {{2{raw_t[IN_W-1]}}, raw_t};
        f0 = {{2{raw_f[IN_W-1]}}, raw_f};
        // phase -> step carry
        if (p1 >= P_RAD) begin
            p1 = p1 - P_RAD;
            t0 = t0 + ONE;
        end else if (p1 < ZERO) begin
            p1 = p1 + P_RAD;
            t0 = t0 - ONE;
        end
        // step -> frame carry
        t1 = t0;
        if (t1 >= radix) begin
            t1 = t1 - radix;
            f0 = f0 + ONE;
        end else if (t1 < ZERO) begin
            t1 = t1 + radix;
            f0 = f0 - ONE;
        end
        // saturation
        if (f0 < ZERO) begin
            norm.f   = '0;
            norm.t   = '0;
            norm.p   = '0;
            norm.err = 1'b1;
        end else if (f0 >= F_TOP) begin
            norm.f   = F_W'(F_LEVELS - 1);
            norm.t   = T_W'(radix - ONE);
            norm.p   = '1;
            norm.err = 1'b1;
        end else begin
            norm.f   = f0[F_W-1:0];
            norm.t   = t1[T_W-1:0];
            norm.p   = p1[P_W-1:0];
            norm.err = 1'b0;
        end
    end
endmodule

// File: rtl/wdly_pack.sv
module wdly_pack
    import wdly_pkg::*;
#(
    parameter int LO_SLOW  = 1,
    parameter int HI_SLOW  = 6,
    parameter int LO_FAST  = 2,
    parameter int HI_FAST  = 9,
    parameter int PIN_T_A  = 9,
    parameter int PIN_T_B  = 10,
    parameter int PIN_P    = 4
) (
    input  logic              fast,
    input  wdly_norm_t        norm,
    input  logic [WORD_W-1:0] cur,
    output logic [WORD_W-1:0] word
);
    localparam logic [T_W-1:0] LS = T_W'(LO_SLOW);
    localparam logic [T_W-1:0] HS = T_W'(HI_SLOW);
    localparam logic [T_W-1:0] LF = T_W'(LO_FAST);
    localparam logic [T_W-1:0] HF = T_W'(HI_FAST);
    localparam logic [T_W-1:0] TA = T_W'(PIN_T_A);
    localparam logic [T_W-1:0] TB = T_W'(PIN_T_B);
    localparam logic [P_W-1:0] PP = P_W'(PIN_P);

    logic [P_W-1:0] p_prog;
    logic [1:0]     region;
    logic [T_W-1:0] lo, hi;

    always_comb begin
        lo = fast ? LF : LS;
        hi = fast ? HF : HS;
        if (norm.t <= lo)      region = 2'b11;
        else if (norm.t > hi)  region = 2'b01;
        else                   region = 2'b00;

        p_prog = norm.p;
        if (fast && (((norm.t == TA) && (norm.p >= PP)) ||
                     ((norm.t == TB) && (norm.p <  PP))))
            p_prog = PP;

        word = cur;
        word[T_LSB +: T_W] = norm.t;
        word[P_LSB +: P_W] = p_prog;
        word[F_LSB +: F_W] = norm.f;
        word[R_LSB +: 2]   = region;
    end
endmodule

// File: rtl/wdly_encoder.sv
module wdly_encoder
    import wdly_pkg::*;
#(
    parameter int IN_W       = 6,
    parameter int RADIX_SLOW = 11,
    parameter int RADIX_FAST = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   fast_mode,
    input  logic signed [IN_W-1:0] in_f,
    input  logic signed [IN_W-1:0] in_t,
    input  logic signed [IN_W-1:0] in_p,
    input  logic [WORD_W-1:0]      cur_word,
    output logic                   out_valid,
    output logic [WORD_W-1:0]      out_word,
    output logic [F_W-1:0]         out_f,
    output logic [T_W-1:0]         out_t,
    output logic [P_W-1:0]         out_p,
    output logic                   out_err
);
    localparam logic [WORD_W-1:0] KEEP = ~((((WORD_W)'(1) << T_W) - 1) << T_LSB |
                                           (((WORD_W)'(1) << P_W) - 1) << P_LSB |
                                           (((WORD_W)'(1) << F_W) - 1) << F_LSB |
                                           (WORD_W)'(3) << R_LSB);

    wdly_state_e       state, state_nx;
    wdly_norm_t        norm;
    logic [WORD_W-1:0] word_nx;

    wdly_normalize #(
        .IN_W(IN_W), .RADIX_SLOW(RADIX_SLOW), .RADIX_FAST(RADIX_FAST), .F_LEVELS(4)
    ) u_norm (
        .fast(fast_mode), .raw_f(in_f), .raw_t(in_t), .raw_p(in_p), .norm(norm)
    );

    wdly_pack u_pack (
        .fast(fast_mode), .norm(norm), .cur(cur_word), .word(word_nx)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_f    <= '0;
            out_t    <= '0;
            out_p    <= '0;
            out_err  <= 1'b0;
        end else if (in_valid) begin
            out_word <= word_nx;
            out_f    <= norm.f;
            out_t    <= norm.t;
            out_p    <= norm.p;
            out_err  <= norm.err;
        end
    end

    assign out_valid = (state == ST_EMIT);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    a_r3_step_below_radix: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_t) < ($past(fast_mode) ? RADIX_FAST : RADIX_SLOW)));
    a_r5_sat_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |->
        ((out_f == '0 && out_t == '0 && out_p == '0) ||
         (out_f == '1 && out_p == '1 &&
          int'(out_t) == ($past(fast_mode) ? RADIX_FAST : RADIX_SLOW) - 1)));
    a_r7_slow_no_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(fast_mode)) |-> out_word[P_LSB +: P_W] == out_p);
    a_r8_zero_step_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_t == '0) |-> out_word[R_LSB +: 2] == 2'b11);
    a_r9_fields: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[T_LSB +: T_W] == out_t && out_word[F_LSB +: F_W] == out_f));
    a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_word & KEEP) == ($past(cur_word) & KEEP)));
endmodule

// File: tb/sim_wdly_encoder.sv
`timescale 1ns/1ps
module sim_wdly_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        fast_mode = 1'b0;
    logic [5:0]  in_f = '0, in_t = '0, in_p = '0;
    logic [31:0] cur_word = '0;
    logic        out_valid;
    logic [31:0] out_word;
    logic [1:0]  out_f;
    logic [3:0]  out_t;
    logic [2:0]  out_p;
    logic        out_err;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    wdly_encoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fast_mode(fast_mode),
        .in_f(in_f), .in_t(in_t), .in_p(in_p), .cur_word(cur_word),
        .out_valid(out_valid), .out_word(out_word), .out_f(out_f),
        .out_t(out_t), .out_p(out_p), .out_err(out_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input int f, input int t, input int p, input bit fast,
                                  input logic [31:0] cur, output logic [31:0] w,
                                  output int fo, output int to, output int po, output bit e);
        int r, pp, lo, hi, rg;
        r = fast ? 12 : 11;
        if (p >= 8) begin p -= 8; t++; end else if (p < 0) begin p += 8; t--; end
        if (t >= r) begin t -= r; f++; end else if (t < 0) begin t += r; f--; end
        e = 1'b0;
        if (f < 0) begin f = 0; t = 0; p = 0; e = 1'b1; end
        else if (f >= 4) begin f = 3; t = r - 1; p = 7; e = 1'b1; end
        pp = p;
        if (fast && ((t == 9 && p >= 4) || (t == 10 && p < 4))) pp = 4;
        lo = fast ? 2 : 1;
        hi = fast ? 9 : 6;
        rg = (t <= lo) ? 3 : ((t > hi) ? 1 : 0);
        w = (cur & 32'h08F0FFFF) | (32'(t) << 28) | (32'(pp) << 24) | (32'(f) << 18) | (32'(rg) << 16);
        fo = f; to = t; po = p;
    endfunction

    task automatic apply(input int f, input int t, input int p, input bit fast,
                         input logic [31:0] cur, input string tag);
        logic [31:0] w;
        int fo, to, po;
        bit e;
        model(f, t, p, fast, cur, w, fo, to, po, e);
        @(negedge clk);
        in_f = 6'(f); in_t = 6'(t); in_p = 6'(p);
        fast_mode = fast; cur_word = cur; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_f = 6'(f + 1); cur_word = ~cur;
        chk(out_valid == 1'b1, "R1 valid", 32'(out_valid), 32'd1);
        chk(out_word == w, {tag, " word"}, out_word, w);
        chk(out_f == 2'(fo) && out_t == 4'(to) && out_p == 3'(po),
            {tag, " digits"}, {23'd0, out_f, out_t, out_p}, {23'd0, 2'(fo), 4'(to), 3'(po)});
        chk(out_err == e, {tag, " err"}, 32'(out_err), 32'(e));
        @(negedge clk);
        chk(out_valid == 1'b0 && out_word == w, "R1 hold", out_word, w);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_word == 0 && out_err == 0 && out_f == 0 && out_t == 0 && out_p == 0,
            "R11 reset", out_word, 32'd0);
        rst_n = 1'b1;
        // R2 phase carry / borrow
        apply(1, 3, 9, 0, 32'h0, "R2 carry");
        apply(1, 3, -1, 0, 32'h0, "R2 borrow");
        // R3 radix per mode
        apply(0, 11, 0, 0, 32'h0, "R3 slow wrap");
        apply(0, 11, 0, 1, 32'h0, "R3 fast no wrap");
        apply(2, -1, 3, 1, 32'h0, "R3 fast borrow");
        // R4 / R5 / R6
        apply(0, 0, -1, 0, 32'hFFFFFFFF, "R4 underflow");
        apply(3, 10, 8, 0, 32'h0, "R5 overflow slow");
        apply(4, 0, 0, 1, 32'h0, "R5 overflow fast");
        apply(3, 10, 7, 0, 32'h0, "R6 top legal");
        // R7 phase pin
        apply(1, 9, 5, 1, 32'h0, "R7 t9 hi");
        apply(1, 10, 2, 1, 32'h0, "R7 t10 lo");
        apply(1, 9, 3, 1, 32'h0, "R7 t9 lo");
        apply(1, 9, 5, 0, 32'h0, "R7 slow");
        // R8 region thresholds
        apply(0, 1, 0, 0, 32'h0, "R8 slow low");
        apply(0, 2, 0, 0, 32'h0, "R8 slow mid");
        apply(0, 6, 0, 0, 32'h0, "R8 slow edge");
        apply(0, 7, 0, 0, 32'h0, "R8 slow high");
        apply(0, 2, 0, 1, 32'h0, "R8 fast low");
        apply(0, 10, 0, 1, 32'h0, "R8 fast high");
        // R9 / R10
        apply(2, 5, 6, 0, 32'hFFFFFFFF, "R10 ones");
        apply(2, 5, 6, 1, 32'hA5A5A5A5, "R9 fields");
        // random deltas
        for (int i = 0; i < 300; i++) begin
            bit fm = 1'($urandom_range(1));
            int r = fm ? 12 : 11;
            int fr = int'($urandom_range(5)) - 1;
            int tr = int'($urandom_range(3 * r - 3)) - (r - 1);
            int pr = int'($urandom_range(23)) - 8;
            apply(fr, tr, pr, fm, $urandom(), "R9 random");
        end
        // back-to-back strobes (R1)
        @(negedge clk);
        in_f = 6'd1; in_t = 6'd4; in_p = 6'd2; fast_mode = 0; cur_word = 0; in_valid = 1;
        @(negedge clk);
        in_t = 6'd5;
        @(negedge clk);
        in_valid = 0;
        chk(out_valid == 1'b1 && out_t == 4'd5, "R1 back-to-back", {28'd0, out_t}, 32'd5);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule